// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state. After reset it drives the device command bus through a fixed bring-up order. First comes a long settling wait made only of NOP commands. Then it precharges every bank. Two auto-refresh commands follow, and the last command programs the mode register. A gap timer enforces the spacing between successive commands, and NOPs fill each gap. When the delay after the mode load has run out, the block raises a ready flag. A normal memory controller can then take over the bus.

All timing is given as cycle counts. The settling wait defaults to 25000 cycles, which is 100 µs at 250 MHz. The precharge-to-command, refresh-to-command and mode-load-to-ready gaps each have their own parameter. The mode register word is built from separate configuration inputs: burst length code, burst ordering, CAS latency code and write burst mode. The block presents this word on the address bus in the load cycle. Any reset, even one in the middle of the sequence, starts the whole order again from the settling wait.

Top module: `sdram_bringup_seq`

## Requirements
- R1: The cycle in which reset is registered and every cycle of reset show the following. The command is NOP, written as (cs_n, ras_n, cas_n, we_n) = 0,1,1,1. The address and bank outputs are all zero, and init_done is low.
- R2: Counting cycle 0 as the first cycle after reset is released, cycles 0 to T_WAIT-1 carry only NOP. T_WAIT is at least 1, so at least one NOP always precedes the first real command.
- R3: Cycle T_WAIT carries PRECHARGE, encoded 0,0,1,0. In that cycle address bit 10 is high, all other address bits are low, and the bank bits are zero.
- R4: AUTO REFRESH, encoded 0,0,0,1, is issued exactly twice, in cycle T_WAIT+T_RP and in cycle T_WAIT+T_RP+T_RC. Address and bank bits are zero in those cycles.
- R5: LOAD MODE, encoded 0,0,0,0, is issued once, in cycle T_WAIT+T_RP+2*T_RC, with the bank bits held at zero.
- R6: In the load cycle, address bits 2:0 equal cfg_burst_len and bit 3 equals cfg_burst_interleave. Bits 6:4 equal cfg_cas_lat and bits 8:7 are 00. Bit 9 equals cfg_wr_single. Bits 10 and above, bit 12 included, are zero.
- R7: Every cycle other than the four command cycles carries NOP with zero address and bank bits.
- R8: init_done goes high in cycle T_WAIT+T_RP+2*T_RC+T_MRD. It stays high, with NOP on the bus, until the next reset.
- R9: A reset applied at any point, including a command cycle or after init_done, aborts the sequence. After release, the full timing of R2 to R8 is repeated from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, restarts the sequence |
| cfg_burst_len | input | 3 | Burst length code placed in mode bits 2:0 |
| cfg_burst_interleave | input | 1 | Burst ordering, 1 = interleaved, placed in mode bit 3 |
| cfg_cas_lat | input | 3 | CAS latency code placed in mode bits 6:4 |
| cfg_wr_single | input | 1 | Write burst mode, 1 = single-location writes, placed in mode bit 9 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W (13) | Address bus, carries A10 for precharge-all and the mode word |
| sd_ba | output | BA_W (2) | Bank select, zero throughout the sequence |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Reset and command issue can fall in the same cycle. A reset can arrive exactly when the precharge or the mode load is on the bus, or after init_done. The bench raises reset in those cycles on purpose and also at random points of the sequence. It checks that the command still in progress is shown unchanged, and that the next cycle is a clean NOP with init_done low. After release, every cycle of the rerun is compared against timing derived only from the cycle counts and the randomly chosen mode fields.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_PRECH,
        ST_REF_A,
        ST_REF_B,
        ST_MODE,
        ST_READY
    } bring_state_t;

    typedef struct packed {
        logic       wr_single;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst_len;
    } mode_cfg_t;

    localparam int MODE_W     = 12;
    localparam int PRE_ALL_BIT = 10;

    // Base mode word: operating mode field fixed at standard (00), reserved bits zero.
    function automatic logic [MODE_W-1:0] pack_mode(input mode_cfg_t c);
        logic [MODE_W-1:0] w;
        w       = '0;
        w[2:0]  = c.burst_len;
        w[3]    = c.interleave;
        w[6:4]  = c.cas_lat;
        w[8:7]  = 2'b00;
        w[9]    = c.wr_single;
        return w;
    endfunction

    function automatic bring_state_t step_after(input bring_state_t s);
        case (s)
            ST_SETTLE: return ST_PRECH;
            ST_PRECH:  return ST_REF_A;
            ST_REF_A:  return ST_REF_B;
            ST_REF_B:  return ST_MODE;
            default:   return ST_READY;
        endcase
    endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RST_VAL;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2: once run down and not reloaded, the timer never wraps around
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/init_mode_pack.sv
module init_mode_pack
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  mode_cfg_t         cfg,
    output logic [ADDR_W-1:0] word
);
    logic [MODE_W-1:0] base;

    assign base = pack_mode(cfg);

    generate
        if (ADDR_W > MODE_W) begin : g_wide
            assign word = {{(ADDR_W-MODE_W){1'b0}}, base};
        end else begin : g_narrow
            assign word = base[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int T_WAIT = 25000,
    parameter int T_RP   = 5,
    parameter int T_RC   = 16,
    parameter int T_MRD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_wr_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done
);
    localparam int MAX_A  = (T_WAIT > T_RP) ? T_WAIT : T_RP;
    localparam int MAX_B  = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_V + 1);
    localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(T_WAIT - 1);
    localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] MRD_LD  = CNT_W'(T_MRD - 1);

    bring_state_t      state_q, state_nx;
    logic              first_q;
    logic              gap_over;
    logic              advance;
    logic [CNT_W-1:0]  gap_ld;
    mode_cfg_t         cfg;
    logic [ADDR_W-1:0] mode_word;
    sd_cmd_t           cmd_now;

    assign cfg = '{wr_single: cfg_wr_single, cas_lat: cfg_cas_lat,
                   interleave: cfg_burst_interleave, burst_len: cfg_burst_len};

    init_mode_pack #(.ADDR_W(ADDR_W)) u_pack (
        .cfg  (cfg),
        .word (mode_word)
    );

    assign advance  = gap_over && (state_q != ST_READY);
    assign state_nx = step_after(state_q);

    always_comb begin
        case (state_nx)
            ST_PRECH: gap_ld = RP_LD;
            ST_REF_A: gap_ld = RC_LD;
            ST_REF_B: gap_ld = RC_LD;
            ST_MODE:  gap_ld = MRD_LD;
            default:  gap_ld = '0;
        endcase
    end

    init_gap_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_LD)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (gap_ld),
        .expired  (gap_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            first_q <= 1'b0;
        end else if (advance) begin
            state_q <= state_nx;
            first_q <= (state_nx != ST_READY);
        end else begin
            first_q <= 1'b0;
        end
    end

    always_comb begin
        cmd_now = CMD_NOP;
        sd_addr = '0;
        if (first_q) begin
            case (state_q)
                ST_PRECH: begin
                    cmd_now = CMD_PRE;
                    sd_addr[PRE_ALL_BIT] = 1'b1;
                end
                ST_REF_A, ST_REF_B: cmd_now = CMD_AREF;
                ST_MODE: begin
                    cmd_now = CMD_LMR;
                    sd_addr = mode_word;
                end
                default: cmd_now = CMD_NOP;
            endcase
        end
    end

    assign sd_cs_n   = cmd_now.cs_n;
    assign sd_ras_n  = cmd_now.ras_n;
    assign sd_cas_n  = cmd_now.cas_n;
    assign sd_we_n   = cmd_now.we_n;
    assign sd_ba     = '0;
    assign init_done = (state_q == ST_READY);

    // R8: ready flag is sticky until reset
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R8: bus stays idle once ready
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd_now == CMD_NOP));

    // R3: precharge covers all banks
    p_prech_all_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_now == CMD_PRE) |-> sd_addr[PRE_ALL_BIT]);

    // R5: bank bits zero during the mode load
    p_load_bank_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_now == CMD_LMR) |-> (sd_ba == '0));

    // R6: operating mode and reserved bits zero in the mode word
    p_mode_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_now == CMD_LMR) |-> ((sd_addr[8:7] == 2'b00) && ((sd_addr >> 10) == '0)));

    // R9: first cycle after reset release is idle and not ready
    p_restart_clean_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!init_done && cmd_now == CMD_NOP));

endmodule

// File: tb/sdram_bringup_seq_tb.sv
`timescale 1ns/1ps
module sdram_bringup_seq_tb;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int TW     = 40;
    localparam int TRP    = 3;
    localparam int TRC    = 7;
    localparam int TMRD   = 2;
    localparam int I_PRE  = TW;
    localparam int I_REF1 = TW + TRP;
    localparam int I_REF2 = TW + TRP + TRC;
    localparam int I_LMR  = TW + TRP + 2*TRC;
    localparam int I_DONE = I_LMR + TMRD;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        bl = 3'd0;
    logic              bt = 1'b0;
    logic [2:0]        cl = 3'd0;
    logic              wb = 1'b0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    logic              done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_bringup_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .T_WAIT(TW), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)
    ) u_dut (
        .clk(clk), .rst(rst),
        .cfg_burst_len(bl), .cfg_burst_interleave(bt), .cfg_cas_lat(cl), .cfg_wr_single(wb),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(addr), .sd_ba(ba), .init_done(done)
    );

    function automatic logic [3:0] exp_cmd(input int i);
        if (i == I_PRE)                    return 4'b0010;
        if (i == I_REF1 || i == I_REF2)    return 4'b0001;
        if (i == I_LMR)                    return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int i);
        logic [ADDR_W-1:0] a;
        a = '0;
        if (i == I_PRE) a[10] = 1'b1;
        if (i == I_LMR) begin
            a[2:0] = bl; a[3] = bt; a[6:4] = cl; a[9] = wb;
        end
        return a;
    endfunction

    function automatic string tag_of(input int i);
        if (i < TW)                        return "R2";
        if (i == I_PRE)                    return "R3";
        if (i == I_REF1 || i == I_REF2)    return "R4";
        if (i == I_LMR)                    return "R5";
        return "R7";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_cycle(input int i);
        check(tag_of(i), $sformatf("cmd cycle %0d", i), {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_cmd(i)});
        check((i == I_LMR) ? "R6" : tag_of(i), $sformatf("addr cycle %0d", i), 32'(addr), 32'(exp_addr(i)));
        check((i == I_LMR) ? "R5" : "R7", $sformatf("bank cycle %0d", i), 32'(ba), 32'd0);
        check("R8", $sformatf("done cycle %0d", i), {31'd0, done}, {31'd0, (i >= I_DONE)});
    endtask

    task automatic check_reset(input string tag);
        check(tag, "reset cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check(tag, "reset addr", 32'(addr), 32'd0);
        check(tag, "reset bank", 32'(ba), 32'd0);
        check(tag, "reset done", {31'd0, done}, 32'd0);
    endtask

    // Release reset, check cycles 0..last, then raise reset in the next cycle.
    task automatic run_trial(input int last);
        @(posedge clk); #1 rst = 1'b0;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            check_cycle(i);
        end
        @(posedge clk); #1 rst = 1'b1;
        @(negedge clk);
        check_cycle(last + 1);          // R9: cycle coinciding with reset still shows its command
        @(posedge clk);
        @(negedge clk);
        check_reset("R9");
    endtask

    task automatic set_mode(input logic [2:0] b, input logic t, input logic [2:0] c, input logic w);
        bl = b; bt = t; cl = c; wb = w;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk);
        @(negedge clk);
        check_reset("R1");
        set_mode(3'b011, 1'b1, 3'b011, 1'b1);
        run_trial(I_DONE + 12);
        set_mode(3'b010, 1'b0, 3'b010, 1'b0);
        run_trial(I_PRE - 1);           // reset lands on the precharge cycle
        set_mode(3'b111, 1'b0, 3'b001, 1'b1);
        run_trial(I_LMR - 1);           // reset lands on the mode-load cycle
        set_mode(3'b000, 1'b1, 3'b111, 1'b0);
        run_trial(0);
        for (int k = 0; k < 8; k++) begin
            set_mode(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                     3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
            run_trial(int'($urandom_range(0, I_DONE + 6)));
        end
        set_mode(3'b001, 1'b0, 3'b010, 1'b1);
        run_trial(I_DONE + 4);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule